// File: doc/BRIEF.md
# Dual-issue hazard and stall controller

This block is the hazard controller of a two-slot in-order pipeline whose stages are decode, execute, data access and writeback. Each cycle it looks at the pair of instructions in decode (slot 0 is the older, slot 1 the younger) and at the instruction classes and destination registers of the instructions further down the pipe. From these it decides whether the pair moves on, whether only slot 1 is held back, or whether both are held. It also kills the younger decode slot, or both decode slots, when a jump resolves as taken, because fetch always assumes that jumps fall through.

The same comparisons drive the operand multiplexer selects for both decode slots. An operand comes from the register file, from the youngest in-flight writer of the same register, from the program counter, from the immediate field, or from the constant four used to build a return address. The block holds no state and adds no cycle. Its outputs settle within the cycle in which its inputs change.

Instruction class codes on every `*_cls` input: 0 empty, 1 ALU, 2 multiply (three-cycle), 3 load-immediate, 4 load, 5 store, 6 store with base update, 7 compare, 8 relative jump, 9 register jump, 10 predicate bank change. Classes 1, 2, 3, 4 and 6 write the register file. Classes 1, 2, 4, 5, 6, 7 and 9 read the first source register. Classes 1, 2, 5, 6 and 7 read the second source register unless the immediate flag is set. Classes 4, 5 and 6 use the load/store pipe. A decode instruction is *valid* when `dr_live` and `dr_guard` are both 1. An in-flight instruction counts only when its `*_vld` bit is 1.

Top module: `hzd_pair_ctrl`

## Requirements
- R1: When valid slot 0 writes the register file (classes 1, 2, 3, 4, 6), its destination is not register 0, and valid slot 1 reads that register, `stall_s1` is 1 and `stall_all` is 0.
- R2: When valid slots 0 and 1 both hold load/store-pipe classes (4, 5, 6), `stall_s1` is 1.
- R3: When valid slot 0 is a compare or bank change (7, 10) and slot 1 is present (`dr_live[1]`, whatever its guard) and is a jump or bank change (8, 9, 10), `stall_s1` is 1. When valid slot 0 is a bank change, any present slot 1 gives `stall_s1` = 1.
- R4: A valid multiply or load (2, 4) in execute whose destination a valid decode slot reads holds that slot: slot 0 gives `stall_all` = 1, slot 1 gives `stall_s1` = 1. The same applies when a valid compare or bank change is in execute and the decode slot is a bank change.
- R5: A valid multiply in the data stage holds a valid decode slot that reads its destination, or that writes the register file and is not itself a multiply. Slot 0 gives `stall_all`, slot 1 gives `stall_s1`.
- R6: Decode or in-flight instructions whose guard or valid bit is 0 neither raise nor cause a data hazard stall, and a slot-0 jump with a false guard cancels nothing.
- R7: A valid taken jump (8, 9) in either execute slot gives `cancel_all` = 1. A valid slot-0 jump with `dr0_taken` = 1 that is not held gives `cancel_s1` = 1.
- R8: `stall_all` and `stall_s1` are never both 1. While `cancel_all` is 1, every other stall and cancel output is 0. While `cancel_s1` is 1, no stall is raised.
- R9: Select codes: 0 register file, 1 execute slot 1, 2 execute slot 0, 3 data slot 1, 4 data slot 0, 5 writeback slot 1, 6 writeback slot 0, 7 PC, 8 immediate, 9 constant four. A read source operand takes the lowest matching code among in-flight valid writers of the same register, so the youngest writer wins. Otherwise it takes 0.
- R10: A jump-and-link decode slot (`dr_link`) gets operand 1 = PC (7) and operand 2 = four (9). Otherwise a set `dr_imm` gives operand 2 = immediate (8).
- R11: Register 0 is never forwarded and never matches in any hazard check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dr_live | input | 2 | Decode slot holds an instruction |
| dr_guard | input | 2 | Decode slot guard predicate is true |
| dr_cls | input | 2x4 | Decode slot class codes |
| dr0_rd | input | RW | Slot 0 destination register |
| dr_rs1 | input | 2xRW | First source register per slot |
| dr_rs2 | input | 2xRW | Second source register per slot |
| dr_imm | input | 2 | Operand 2 is the immediate field |
| dr_link | input | 2 | Jump-and-link in the slot |
| dr0_taken | input | 1 | Slot 0 jump resolved taken |
| ex_vld | input | 2 | Execute slot valid |
| ex_cls | input | 2x4 | Execute slot classes |
| ex_rd | input | 2xRW | Execute slot destinations |
| ex_taken | input | 2 | Execute slot jump taken |
| df_vld | input | 2 | Data-stage slot valid |
| df_cls | input | 2x4 | Data-stage slot classes |
| df_rd | input | 2xRW | Data-stage destinations |
| wb_vld | input | 2 | Writeback slot valid and writing |
| wb_rd | input | 2xRW | Writeback destinations |
| stall_all | output | 1 | Hold both decode slots |
| stall_s1 | output | 1 | Hold slot 1 only |
| cancel_all | output | 1 | Kill both decode slots |
| cancel_s1 | output | 1 | Kill slot 1 |
| op1_sel | output | 2x4 | Operand 1 select per slot |
| op2_sel | output | 2x4 | Operand 2 select per slot |

## Verification
The block is combinational, so a wrong term in any hazard or priority check shows on the stall, cancel or select ports in the same cycle as the input pattern that exercises it. A missing stall lets the consumer read stale data one cycle later. A spurious one costs throughput. A wrong priority picks an older copy of the register. The bench therefore compares every output against a behavioural model on every cycle of both directed and biased random patterns, with register numbers drawn from a small range so that matches are frequent.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int CLS_W = 4;
    localparam int SEL_W = 4;

    typedef enum logic [CLS_W-1:0] {
        C_NOP  = 4'd0,
        C_ALU  = 4'd1,
        C_MUL  = 4'd2,
        C_LDI  = 4'd3,
        C_LD   = 4'd4,
        C_ST   = 4'd5,
        C_STU  = 4'd6,
        C_CMP  = 4'd7,
        C_JMP  = 4'd8,
        C_JMPR = 4'd9,
        C_BANK = 4'd10
    } icls_e;

    // Lower code = younger producer; the forwarding search depends on this order.
    typedef enum logic [SEL_W-1:0] {
        F_REG  = 4'd0,
        F_EX1  = 4'd1,
        F_EX0  = 4'd2,
        F_DF1  = 4'd3,
        F_DF0  = 4'd4,
        F_WB1  = 4'd5,
        F_WB0  = 4'd6,
        F_PC   = 4'd7,
        F_IMM  = 4'd8,
        F_FOUR = 4'd9
    } fsel_e;

    typedef struct packed {
        logic stall_all;
        logic stall_s1;
        logic cancel_all;
        logic cancel_s1;
    } ctl_t;

    function automatic logic cls_writes(logic [CLS_W-1:0] c);
        case (c)
            C_ALU, C_MUL, C_LDI, C_LD, C_STU: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

    function automatic logic cls_mem(logic [CLS_W-1:0] c);
        case (c)
            C_LD, C_ST, C_STU: return 1'b1;
            default:           return 1'b0;
        endcase
    endfunction

    function automatic logic cls_rd1(logic [CLS_W-1:0] c);
        case (c)
            C_ALU, C_MUL, C_LD, C_ST, C_STU, C_CMP, C_JMPR: return 1'b1;
            default:                                       return 1'b0;
        endcase
    endfunction

    function automatic logic cls_rd2(logic [CLS_W-1:0] c);
        case (c)
            C_ALU, C_MUL, C_ST, C_STU, C_CMP: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

    function automatic logic cls_jump(logic [CLS_W-1:0] c);
        return (c == C_JMP) || (c == C_JMPR);
    endfunction

    // Instructions that change predicate state: compare and bank change.
    function automatic logic cls_pred(logic [CLS_W-1:0] c);
        return (c == C_CMP) || (c == C_BANK);
    endfunction

    // Results not ready at the end of execute.
    function automatic logic cls_late(logic [CLS_W-1:0] c);
        return (c == C_MUL) || (c == C_LD);
    endfunction

endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter int RW = 5,
    parameter int NP = 6
) (
    input  logic [RW-1:0]         src,
    input  logic                  use_src,
    input  logic                  pick_pc,
    input  logic                  pick_four,
    input  logic                  pick_imm,
    input  logic [NP-1:0]         pvld,
    input  logic [NP-1:0][RW-1:0] prd,
    output logic [SEL_W-1:0]      sel
);

    fsel_e sel_d;
    logic  found;

    // Producers arrive youngest first; the first match wins.
    always_comb begin
        sel_d = F_REG;
        found = 1'b0;
        if (pick_pc) begin
            sel_d = F_PC;
        end else if (pick_four) begin
            sel_d = F_FOUR;
        end else if (pick_imm) begin
            sel_d = F_IMM;
        end else if (use_src && (src != '0)) begin
            for (int i = 0; i < NP; i++) begin
                if (!found && pvld[i] && (prd[i] == src)) begin
                    sel_d = fsel_e'(SEL_W'(i + 1));
                    found = 1'b1;
                end
            end
        end
    end

    assign sel = sel_d;

endmodule

// File: rtl/hzd_stall_core.sv
module hzd_stall_core
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [1:0]            dr_live,
    input  logic [1:0]            dr_guard,
    input  logic [1:0][CLS_W-1:0] dr_cls,
    input  logic [RW-1:0]         dr0_rd,
    input  logic [1:0][RW-1:0]    dr_rs1,
    input  logic [1:0][RW-1:0]    dr_rs2,
    input  logic [1:0]            dr_imm,
    input  logic                  dr0_taken,
    input  logic [1:0]            ex_vld,
    input  logic [1:0][CLS_W-1:0] ex_cls,
    input  logic [1:0][RW-1:0]    ex_rd,
    input  logic [1:0]            ex_taken,
    input  logic [1:0]            df_vld,
    input  logic [1:0][CLS_W-1:0] df_cls,
    input  logic [1:0][RW-1:0]    df_rd,
    output ctl_t                  ctl
);

    ctl_t       ctl_d;
    logic       jmp_e;
    logic [1:0] haz;
    logic       v0, v1;
    logic       pair_haz;
    logic       order_haz;

    function automatic logic reads_reg(logic [CLS_W-1:0] c, logic imm,
                                       logic [RW-1:0] a, logic [RW-1:0] b,
                                       logic [RW-1:0] r);
        return (r != '0) &&
               ((cls_rd1(c) && (a == r)) || (cls_rd2(c) && !imm && (b == r)));
    endfunction

    always_comb begin
        ctl_d = '0;
        v0    = dr_live[0] && dr_guard[0];
        v1    = dr_live[1] && dr_guard[1];

        jmp_e = 1'b0;
        for (int k = 0; k < 2; k++) begin
            if (ex_vld[k] && cls_jump(ex_cls[k]) && ex_taken[k]) jmp_e = 1'b1;
        end

        // Hazards against the execute and data stages, per decode slot.
        for (int s = 0; s < 2; s++) begin
            haz[s] = 1'b0;
            for (int k = 0; k < 2; k++) begin
                if (ex_vld[k] && cls_late(ex_cls[k]) &&
                    reads_reg(dr_cls[s], dr_imm[s], dr_rs1[s], dr_rs2[s], ex_rd[k]))
                    haz[s] = 1'b1;
                if (ex_vld[k] && cls_pred(ex_cls[k]) && (dr_cls[s] == C_BANK))
                    haz[s] = 1'b1;
                if (df_vld[k] && (df_cls[k] == C_MUL) &&
                    (reads_reg(dr_cls[s], dr_imm[s], dr_rs1[s], dr_rs2[s], df_rd[k]) ||
                     (cls_writes(dr_cls[s]) && (dr_cls[s] != C_MUL))))
                    haz[s] = 1'b1;
            end
        end

        pair_haz = v0 && v1 &&
                   ((cls_writes(dr_cls[0]) &&
                     reads_reg(dr_cls[1], dr_imm[1], dr_rs1[1], dr_rs2[1], dr0_rd)) ||
                    (cls_mem(dr_cls[0]) && cls_mem(dr_cls[1])));

        // Slot 1 guard may be stale behind a predicate writer: only presence counts.
        order_haz = v0 && dr_live[1] &&
                    ((cls_pred(dr_cls[0]) &&
                      (cls_jump(dr_cls[1]) || (dr_cls[1] == C_BANK))) ||
                     (dr_cls[0] == C_BANK));

        ctl_d.cancel_all = jmp_e;
        ctl_d.stall_all  = !jmp_e && v0 && haz[0];
        ctl_d.cancel_s1  = !jmp_e && !ctl_d.stall_all && v0 &&
                           cls_jump(dr_cls[0]) && dr0_taken;
        ctl_d.stall_s1   = !jmp_e && !ctl_d.stall_all && !ctl_d.cancel_s1 &&
                           ((v1 && haz[1]) || pair_haz || order_haz);
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/hzd_pair_ctrl.sv
module hzd_pair_ctrl
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [1:0]            dr_live,
    input  logic [1:0]            dr_guard,
    input  logic [1:0][CLS_W-1:0] dr_cls,
    input  logic [RW-1:0]         dr0_rd,
    input  logic [1:0][RW-1:0]    dr_rs1,
    input  logic [1:0][RW-1:0]    dr_rs2,
    input  logic [1:0]            dr_imm,
    input  logic [1:0]            dr_link,
    input  logic                  dr0_taken,
    input  logic [1:0]            ex_vld,
    input  logic [1:0][CLS_W-1:0] ex_cls,
    input  logic [1:0][RW-1:0]    ex_rd,
    input  logic [1:0]            ex_taken,
    input  logic [1:0]            df_vld,
    input  logic [1:0][CLS_W-1:0] df_cls,
    input  logic [1:0][RW-1:0]    df_rd,
    input  logic [1:0]            wb_vld,
    input  logic [1:0][RW-1:0]    wb_rd,
    output logic                  stall_all,
    output logic                  stall_s1,
    output logic                  cancel_all,
    output logic                  cancel_s1,
    output logic [1:0][SEL_W-1:0] op1_sel,
    output logic [1:0][SEL_W-1:0] op2_sel
);

    localparam int NP = 6;

    logic [NP-1:0]         pvld_d;
    logic [NP-1:0][RW-1:0] prd_d;
    ctl_t                  ctl;

    // Producer list, youngest first: EX1, EX0, DF1, DF0, WB1, WB0.
    always_comb begin
        for (int j = 0; j < 2; j++) begin
            pvld_d[1-j]   = ex_vld[j] && cls_writes(ex_cls[j]);
            prd_d[1-j]    = ex_rd[j];
            pvld_d[3-j]   = df_vld[j] && cls_writes(df_cls[j]);
            prd_d[3-j]    = df_rd[j];
            pvld_d[5-j]   = wb_vld[j];
            prd_d[5-j]    = wb_rd[j];
        end
    end

    hzd_stall_core #(.RW(RW)) u_core (
        .dr_live   (dr_live),
        .dr_guard  (dr_guard),
        .dr_cls    (dr_cls),
        .dr0_rd    (dr0_rd),
        .dr_rs1    (dr_rs1),
        .dr_rs2    (dr_rs2),
        .dr_imm    (dr_imm),
        .dr0_taken (dr0_taken),
        .ex_vld    (ex_vld),
        .ex_cls    (ex_cls),
        .ex_rd     (ex_rd),
        .ex_taken  (ex_taken),
        .df_vld    (df_vld),
        .df_cls    (df_cls),
        .df_rd     (df_rd),
        .ctl       (ctl)
    );

    assign stall_all  = ctl.stall_all;
    assign stall_s1   = ctl.stall_s1;
    assign cancel_all = ctl.cancel_all;
    assign cancel_s1  = ctl.cancel_s1;

    for (genvar s = 0; s < 2; s++) begin : g_slot
        hzd_fwd_sel #(.RW(RW), .NP(NP)) u_op1 (
            .src       (dr_rs1[s]),
            .use_src   (cls_rd1(dr_cls[s])),
            .pick_pc   (dr_link[s]),
            .pick_four (1'b0),
            .pick_imm  (1'b0),
            .pvld      (pvld_d),
            .prd       (prd_d),
            .sel       (op1_sel[s])
        );
        hzd_fwd_sel #(.RW(RW), .NP(NP)) u_op2 (
            .src       (dr_rs2[s]),
            .use_src   (cls_rd2(dr_cls[s])),
            .pick_pc   (1'b0),
            .pick_four (dr_link[s]),
            .pick_imm  (dr_imm[s] && !dr_link[s]),
            .pvld      (pvld_d),
            .prd       (prd_d),
            .sel       (op2_sel[s])
        );
    end

endmodule

// File: rtl/hzd_pair_ctrl_chk.sv
module hzd_pair_ctrl_chk
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input logic [1:0]            dr_live,
    input logic [1:0]            dr_guard,
    input logic [1:0][CLS_W-1:0] dr_cls,
    input logic [1:0][RW-1:0]    dr_rs1,
    input logic [1:0]            dr_link,
    input logic                  stall_all,
    input logic                  stall_s1,
    input logic                  cancel_all,
    input logic                  cancel_s1,
    input logic [1:0][SEL_W-1:0] op1_sel,
    input logic [1:0][SEL_W-1:0] op2_sel
);

    always_comb begin
        AST_STALL_EXCLUSIVE: assert (!(stall_all && stall_s1)); // R8
        AST_CANCEL_ALL_QUIET: assert (!cancel_all || !(stall_all || stall_s1 || cancel_s1)); // R8
        AST_CANCEL_S1_NO_STALL: assert (!cancel_s1 || !(stall_all || stall_s1)); // R7
        AST_CANCEL_S1_NEEDS_VALID_JUMP: assert (!cancel_s1 ||
            (dr_live[0] && dr_guard[0] && cls_jump(dr_cls[0]))); // R6
        for (int s = 0; s < 2; s++) begin
            AST_LINK_OPERANDS: assert (!dr_link[s] ||
                ((op1_sel[s] == F_PC) && (op2_sel[s] == F_FOUR))); // R10
            AST_ZERO_REG_UNFORWARDED: assert (dr_link[s] || (dr_rs1[s] != '0) ||
                (op1_sel[s] == F_REG)); // R11
        end
    end

endmodule

bind hzd_pair_ctrl hzd_pair_ctrl_chk #(.RW(RW)) u_chk (
    .dr_live    (dr_live),
    .dr_guard   (dr_guard),
    .dr_cls     (dr_cls),
    .dr_rs1     (dr_rs1),
    .dr_link    (dr_link),
    .stall_all  (stall_all),
    .stall_s1   (stall_s1),
    .cancel_all (cancel_all),
    .cancel_s1  (cancel_s1),
    .op1_sel    (op1_sel),
    .op2_sel    (op2_sel)
);

// File: tb/hzd_pair_ctrl_test.sv
`timescale 1ns/1ps
module hzd_pair_ctrl_test;

    localparam int RW = 5;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]         dr_live   = '0;
    logic [1:0]         dr_guard  = '0;
    logic [1:0][3:0]    dr_cls    = '0;
    logic [RW-1:0]      dr0_rd    = '0;
    logic [1:0][RW-1:0] dr_rs1    = '0;
    logic [1:0][RW-1:0] dr_rs2    = '0;
    logic [1:0]         dr_imm    = '0;
    logic [1:0]         dr_link   = '0;
    logic               dr0_taken = 1'b0;
    logic [1:0]         ex_vld    = '0;
    logic [1:0][3:0]    ex_cls    = '0;
    logic [1:0][RW-1:0] ex_rd     = '0;
    logic [1:0]         ex_taken  = '0;
    logic [1:0]         df_vld    = '0;
    logic [1:0][3:0]    df_cls    = '0;
    logic [1:0][RW-1:0] df_rd     = '0;
    logic [1:0]         wb_vld    = '0;
    logic [1:0][RW-1:0] wb_rd     = '0;
    logic               stall_all, stall_s1, cancel_all, cancel_s1;
    logic [1:0][3:0]    op1_sel, op2_sel;

    hzd_pair_ctrl #(.RW(RW)) uut (.*);

    int n_chk  = 0;
    int n_fail = 0;
    int m_sa, m_s1, m_ca, m_cs1;
    int m_op1 [2];
    int m_op2 [2];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit in_set(int c, int a, int b, int d, int e, int f, int g, int h);
        return c == a || c == b || c == d || c == e || c == f || c == g || c == h;
    endfunction
    function automatic bit b_wr(int c);   return in_set(c, 1, 2, 3, 4, 6, 6, 6); endfunction
    function automatic bit b_mem(int c);  return in_set(c, 4, 5, 6, 6, 6, 6, 6); endfunction
    function automatic bit b_r1(int c);   return in_set(c, 1, 2, 4, 5, 6, 7, 9); endfunction
    function automatic bit b_r2(int c);   return in_set(c, 1, 2, 5, 6, 7, 7, 7); endfunction
    function automatic bit b_jmp(int c);  return c == 8 || c == 9; endfunction
    function automatic bit b_pred(int c); return c == 7 || c == 10; endfunction

    function automatic bit uses(int s, int r);
        int c = int'(dr_cls[s]);
        if (r == 0) return 0;
        return (b_r1(c) && int'(dr_rs1[s]) == r) ||
               (b_r2(c) && !dr_imm[s] && int'(dr_rs2[s]) == r);
    endfunction

    function automatic bit late_haz(int s);
        bit h = 0;
        for (int k = 0; k < 2; k++) begin
            int ec = int'(ex_cls[k]);
            int fc = int'(df_cls[k]);
            int dc = int'(dr_cls[s]);
            if (ex_vld[k] && (ec == 2 || ec == 4) && uses(s, int'(ex_rd[k]))) h = 1;
            if (ex_vld[k] && b_pred(ec) && dc == 10) h = 1;
            if (df_vld[k] && fc == 2 && (uses(s, int'(df_rd[k])) || (b_wr(dc) && dc != 2))) h = 1;
        end
        return h;
    endfunction

    function automatic int pick(int src, bit rd);
        if (!rd || src == 0) return 0;
        for (int j = 0; j < 6; j++) begin
            int slot = 1 - (j % 2);
            int stg  = j / 2;
            bit pv;
            int pr;
            if (stg == 0) begin pv = ex_vld[slot] && b_wr(int'(ex_cls[slot])); pr = int'(ex_rd[slot]); end
            else if (stg == 1) begin pv = df_vld[slot] && b_wr(int'(df_cls[slot])); pr = int'(df_rd[slot]); end
            else begin pv = wb_vld[slot]; pr = int'(wb_rd[slot]); end
            if (pv && pr == src) return j + 1;
        end
        return 0;
    endfunction

    task automatic model();
        bit v0 = dr_live[0] && dr_guard[0];
        bit v1 = dr_live[1] && dr_guard[1];
        int c0 = int'(dr_cls[0]);
        int c1 = int'(dr_cls[1]);
        bit hold1;
        m_ca = 0; m_sa = 0; m_cs1 = 0; m_s1 = 0;
        for (int k = 0; k < 2; k++)
            if (ex_vld[k] && b_jmp(int'(ex_cls[k])) && ex_taken[k]) m_ca = 1;
        if (m_ca == 0) begin
            if (v0 && late_haz(0)) m_sa = 1;
            else if (v0 && b_jmp(c0) && dr0_taken) m_cs1 = 1;
            else begin
                hold1 = (v1 && late_haz(1)) ||
                        (v0 && v1 && b_wr(c0) && uses(1, int'(dr0_rd))) ||
                        (v0 && v1 && b_mem(c0) && b_mem(c1)) ||
                        (v0 && dr_live[1] && ((b_pred(c0) && (b_jmp(c1) || c1 == 10)) || c0 == 10));
                m_s1 = hold1 ? 1 : 0;
            end
        end
        for (int s = 0; s < 2; s++) begin
            int c = int'(dr_cls[s]);
            if (dr_link[s]) begin m_op1[s] = 7; m_op2[s] = 9; end
            else begin
                m_op1[s] = pick(int'(dr_rs1[s]), b_r1(c));
                m_op2[s] = dr_imm[s] ? 8 : pick(int'(dr_rs2[s]), b_r2(c));
            end
        end
    endtask

    task automatic compare_all(string tag);
        model();
        chk({tag, " R4 stall_all"},  int'(stall_all),  m_sa);
        chk({tag, " R1 stall_s1"},   int'(stall_s1),   m_s1);
        chk({tag, " R7 cancel_all"}, int'(cancel_all), m_ca);
        chk({tag, " R7 cancel_s1"},  int'(cancel_s1),  m_cs1);
        for (int s = 0; s < 2; s++) begin
            chk({tag, " R9 op1_sel"}, int'(op1_sel[s]), m_op1[s]);
            chk({tag, " R10 op2_sel"}, int'(op2_sel[s]), m_op2[s]);
        end
    endtask

    task automatic clear();
        dr_live = '0; dr_guard = '0; dr_cls = '0; dr0_rd = '0; dr_rs1 = '0; dr_rs2 = '0;
        dr_imm = '0; dr_link = '0; dr0_taken = 0; ex_vld = '0; ex_cls = '0; ex_rd = '0;
        ex_taken = '0; df_vld = '0; df_cls = '0; df_rd = '0; wb_vld = '0; wb_rd = '0;
    endtask

    task automatic pair(int c0, int c1);
        dr_live = 2'b11; dr_guard = 2'b11;
        dr_cls[0] = 4'(c0); dr_cls[1] = 4'(c1);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        clear(); settle();
        chk("R8 idle stall_all", int'(stall_all), 0);
        chk("R8 idle stall_s1", int'(stall_s1), 0);
        chk("R9 idle op1", int'(op1_sel[0]), 0);
        compare_all("idle");

        clear(); pair(1, 1); dr0_rd = 3; dr_rs1[1] = 3; settle();
        chk("R1 intra RAW stall_s1", int'(stall_s1), 1);
        chk("R1 intra RAW stall_all", int'(stall_all), 0);

        clear(); pair(4, 5); dr0_rd = 8; dr_rs1[1] = 2; dr_rs2[1] = 9; settle();
        chk("R2 two memory ops", int'(stall_s1), 1);

        clear(); pair(10, 0); dr_guard[1] = 0; settle();
        chk("R3 bank change then anything", int'(stall_s1), 1);

        clear(); pair(7, 8); dr_guard[1] = 0; settle();
        chk("R3 compare then jump", int'(stall_s1), 1);

        clear(); pair(1, 0); ex_vld[0] = 1; ex_cls[0] = 4; ex_rd[0] = 5; dr_rs2[0] = 5; settle();
        chk("R4 load-use slot0 stall_all", int'(stall_all), 1);
        chk("R4 load-use slot0 stall_s1", int'(stall_s1), 0);

        clear(); pair(0, 1); ex_vld[1] = 1; ex_cls[1] = 2; ex_rd[1] = 5; dr_rs1[1] = 5; settle();
        chk("R4 mul-use slot1 stall_s1", int'(stall_s1), 1);
        chk("R4 mul-use slot1 stall_all", int'(stall_all), 0);

        clear(); pair(3, 0); df_vld[0] = 1; df_cls[0] = 2; df_rd[0] = 9; dr0_rd = 4; settle();
        chk("R5 multiply WAW guard", int'(stall_all), 1);

        clear(); pair(2, 0); df_vld[0] = 1; df_cls[0] = 2; df_rd[0] = 9; dr_rs1[0] = 1; dr_rs2[0] = 2; settle();
        chk("R5 multiply behind multiply", int'(stall_all), 0);

        clear(); pair(1, 0); ex_cls[0] = 4; ex_rd[0] = 5; dr_rs1[0] = 5; settle();
        chk("R6 invalid producer ignored", int'(stall_all), 0);

        clear(); pair(1, 1); dr_guard[1] = 0; dr0_rd = 3; dr_rs1[1] = 3; settle();
        chk("R6 invalid consumer not held", int'(stall_s1), 0);

        clear(); pair(1, 1); dr_guard[0] = 0; dr0_rd = 3; dr_rs1[1] = 3; settle();
        chk("R6 invalid slot0 producer", int'(stall_s1), 0);

        clear(); pair(8, 0); dr_guard[0] = 0; dr0_taken = 1; settle();
        chk("R6 false-guard jump cancels nothing", int'(cancel_s1), 0);

        clear(); pair(1, 0); ex_vld = 2'b11; ex_cls[0] = 8; ex_taken[0] = 1; ex_cls[1] = 4; ex_rd[1] = 5; dr_rs1[0] = 5; settle();
        chk("R7 execute jump cancel_all", int'(cancel_all), 1);
        chk("R8 cancel_all hides stall", int'(stall_all), 0);

        clear(); pair(8, 1); dr0_taken = 1; dr_rs1[1] = 6; ex_vld[0] = 1; ex_cls[0] = 4; ex_rd[0] = 6; settle();
        chk("R7 slot0 jump cancel_s1", int'(cancel_s1), 1);
        chk("R8 cancelled slot1 not held", int'(stall_s1), 0);

        clear(); pair(1, 0); dr_rs1[0] = 7; ex_vld = 2'b11; ex_cls[0] = 1; ex_cls[1] = 1; ex_rd[0] = 7; ex_rd[1] = 7;
        df_vld[0] = 1; df_cls[0] = 1; df_rd[0] = 7; settle();
        chk("R9 youngest execute slot1", int'(op1_sel[0]), 1);
        ex_vld[1] = 0; settle();
        chk("R9 execute slot0 next", int'(op1_sel[0]), 2);
        ex_vld[0] = 0; wb_vld[1] = 1; wb_rd[1] = 7; settle();
        chk("R9 data beats writeback", int'(op1_sel[0]), 4);
        df_vld[0] = 0; settle();
        chk("R9 writeback slot1", int'(op1_sel[0]), 5);

        clear(); pair(8, 1); dr_link[0] = 1; dr_imm[1] = 1; settle();
        chk("R10 link op1 PC", int'(op1_sel[0]), 7);
        chk("R10 link op2 four", int'(op2_sel[0]), 9);
        chk("R10 immediate op2", int'(op2_sel[1]), 8);

        clear(); pair(1, 0); dr_rs1[0] = 0; ex_vld[0] = 1; ex_cls[0] = 4; ex_rd[0] = 0; settle();
        chk("R11 r0 not forwarded", int'(op1_sel[0]), 0);
        chk("R11 r0 no hazard", int'(stall_all), 0);

        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #2;
            dr_live = 2'($urandom); dr_guard = 2'($urandom | 32'h1);
            for (int s = 0; s < 2; s++) begin
                dr_cls[s] = 4'($urandom_range(0, 10));
                dr_rs1[s] = RW'($urandom_range(0, 3));
                dr_rs2[s] = RW'($urandom_range(0, 3));
                ex_cls[s] = 4'($urandom_range(0, 10));
                ex_rd[s]  = RW'($urandom_range(0, 3));
                df_cls[s] = 4'($urandom_range(0, 10));
                df_rd[s]  = RW'($urandom_range(0, 3));
                wb_rd[s]  = RW'($urandom_range(0, 3));
            end
            dr0_rd = RW'($urandom_range(0, 3));
            dr_imm = 2'($urandom_range(0, 3) == 0 ? 1 : 0);
            dr_link = 2'($urandom_range(0, 7) == 0 ? 2 : 0);
            dr0_taken = 1'($urandom);
            ex_vld = 2'($urandom); ex_taken = 2'($urandom_range(0, 3) == 0 ? 1 : 0);
            df_vld = 2'($urandom); wb_vld = 2'($urandom);
            settle();
            if (rst_n) compare_all("random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule